// File: doc/BRIEF.md
# Counter-Based Thermal Threshold Monitor

This block is one channel of an on-chip temperature monitor. A front end that sits beside a temperature-dependent ring oscillator reports, on every reference clock cycle, how many oscillator edges it has seen (`oscTicks`). The block adds these increments over a measurement window of N prescaled reference units. One window starts every M units. At the end of each complete window the sum is published as the latest count. A higher count means a hotter die.

The count is compared against three programmable 16-bit thresholds. The number of thresholds that the count meets or exceeds is the thermal level, from 0 to 3. A saturated count is reported as a separate overflow state, and the hardware actions treat it as level 3. Each level drives a hardware action when that action is enabled: a DVFS request, a divide-by-two clock throttle, and an emergency reset request toward the power manager. An interrupt is raised when the level rises across a threshold. Software programs the block and clears pending interrupts through a small word-addressed register bus. Writes take effect on the clock edge and reads are combinational.

Top module: `tmon_top`

## Requirements
- R1: After reset every register reads 0 and all outputs are low. No measurement runs, so status bit 9 stays 0, while M (config bits 23:8) or N (config bits 31:24) is zero or N exceeds M.
- R2: The sum of `oscTicks` over a window of N*PRESCALE consecutive reference cycles is published at the window end in bits 31:16 of the result register (address 4). Windows start every M*PRESCALE cycles.
- R3: A count that reaches 0xFFFF saturates there. The state field then reads 5 (overflow), and the actions treat the state as level 3.
- R4: The state field (status address 3, bits 2:0) holds the number of thresholds met or exceeded by the latest count. TH1 is in address 1 bits 15:0, TH2 in address 1 bits 31:16 and TH3 in address 2 bits 15:0.
- R5: The actions are active only while bit 9 is 1. `dvfsReq` needs level 1 or higher and config bit 3. `clkDivReq` needs level 2 or higher and config bit 1. `thermRst` needs level 3 and config bit 2.
- R6: An interrupt becomes pending (status bit 8, `irq`) only at a window end that raises the level. Reaching level 1 always interrupts. Reaching level 2 interrupts if config bit 5 is set, reaching level 3 if config bit 6 is set, and entering overflow if config bit 4 is set. A falling or unchanged level raises nothing.
- R7: Writing status with bit 8 set clears the pending interrupt. If a window end sets the interrupt in the same cycle, the set wins.
- R8: Status bit 9 (count valid) stays 0 from a start until the first window after that start completes.
- R9: Setting config bit 0 lets a window already in progress finish and store its count, then halts measurement. Valid and the state field clear, the actions drop, no interrupt is raised, and the count is held.
- R10: Config (address 0), thresholds (addresses 1 and 2) read back as written, with config bit 7 reading 0. Writes to address 4 or to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscTicks | input | TICK_W | Oscillator edges seen in this reference cycle |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Pending interrupt |
| dvfsReq | output | 1 | DVFS request action |
| clkDivReq | output | 1 | Divide-by-two clock throttle action |
| thermRst | output | 1 | Emergency reset request to the power manager |

## Verification
The two functions that can fall in the same cycle are the window end that sets a pending interrupt and a software write-one-to-clear of that interrupt. The bench runs one-unit windows back to back. It locates a window boundary from the first rising `irq`, then sets the oscillator rate so that the level rises again exactly 96 cycles later. It times a clear write to land on that edge and expects `irq` to stay high. A clear written one cycle later is expected to drop it. The same sequence checks the per-level interrupt enables: a rise to level 3 with the level-2 and level-3 enables off must leave `irq` low.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  localparam int REG_W   = 32;
  localparam int CNT_W   = 16;
  localparam int THR_W   = 16;
  localparam int PER_W   = 16;
  localparam int WIN_W   = 8;
  localparam int STATE_W = 3;
  localparam logic [STATE_W-1:0] ST_OVF = 3'd5;

  typedef struct packed {
    logic accumulate;
    logic windowEnd;
    logic stopping;
    logic halted;
  } tmonStrobes_t;
endpackage

// File: rtl/tmon_ctrl.sv
module tmon_ctrl
  import tmon_pkg::*;
#(
  parameter int PRESCALE = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgStop,
  input  logic [PER_W-1:0] cfgPeriod,
  input  logic [WIN_W-1:0] cfgWindow,
  output tmonStrobes_t     strobes
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic             running;
  logic [PRE_W-1:0] preCnt;
  logic [PER_W-1:0] periodCnt;
  logic             cfgOk, stopReq, unitTick, inWindow, lastUnit, windowEnd;

  assign cfgOk     = (cfgPeriod != '0) && (cfgWindow != '0) && (PER_W'(cfgWindow) <= cfgPeriod);
  assign stopReq   = cfgStop || !cfgOk;
  assign unitTick  = (preCnt == PRE_W'(PRESCALE - 1));
  assign inWindow  = (periodCnt < PER_W'(cfgWindow));
  assign lastUnit  = (PER_W'(periodCnt + 1'b1) == PER_W'(cfgWindow));
  assign windowEnd = running && inWindow && unitTick && lastUnit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      preCnt    <= '0;
      periodCnt <= '0;
    end else if (!running) begin
      preCnt    <= '0;
      periodCnt <= '0;
      running   <= !stopReq;
    end else if (stopReq && (!inWindow || windowEnd)) begin
      running   <= 1'b0;
      preCnt    <= '0;
      periodCnt <= '0;
    end else begin
      preCnt <= unitTick ? '0 : PRE_W'(preCnt + 1'b1);
      if (unitTick) begin
        periodCnt <= (PER_W'(periodCnt + 1'b1) == cfgPeriod) ? '0 : PER_W'(periodCnt + 1'b1);
      end
    end
  end

  assign strobes.accumulate = running && inWindow;
  assign strobes.windowEnd  = windowEnd;
  assign strobes.stopping   = stopReq;
  assign strobes.halted     = !running;
endmodule

// File: rtl/tmon_datapath.sv
module tmon_datapath
  import tmon_pkg::*;
#(
  parameter int TICK_W = 4,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmonStrobes_t       strobes,
  input  logic [TICK_W-1:0]  oscTicks,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWdata,
  output logic [REG_W-1:0]   regRdata,
  output logic               cfgStop,
  output logic [PER_W-1:0]   cfgPeriod,
  output logic [WIN_W-1:0]   cfgWindow,
  output logic               irq,
  output logic               dvfsReq,
  output logic               clkDivReq,
  output logic               thermRst,
  output logic               validFlag,
  output logic [STATE_W-1:0] stateCode,
  output logic [CNT_W-1:0]   countVal
);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_THA = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_THB = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(4);

  logic enDiv, enRst, enDvfs, irqEnOvf, irqEnDiv, irqEnRst;
  logic [THR_W-1:0] thLow, thMid, thHigh;
  logic [CNT_W-1:0] acc, satSum;
  logic [CNT_W:0]   sumWide;
  logic             ovf, irqSet, irqClr;
  logic [1:0]       lvlNew, effNew, effOld;

  // Saturating sum of the oscillator increments
  assign sumWide = {1'b0, acc} + (CNT_W + 1)'(oscTicks);
  assign satSum  = sumWide[CNT_W] ? '1 : sumWide[CNT_W-1:0];
  assign ovf     = (satSum == '1);
  assign lvlNew  = 2'(satSum >= thLow) + 2'(satSum >= thMid) + 2'(satSum >= thHigh);
  assign effNew  = ovf ? 2'd3 : lvlNew;
  assign effOld  = (stateCode == ST_OVF) ? 2'd3 : stateCode[1:0];

  // Upward crossings only, each gated by its enable (level 1 is unmasked)
  assign irqSet = strobes.windowEnd && !strobes.stopping &&
                  (((effOld < 2'd1) && (effNew >= 2'd1)) ||
                   ((effOld < 2'd2) && (effNew >= 2'd2) && irqEnDiv) ||
                   ((effOld < 2'd3) && (effNew == 2'd3) && irqEnRst) ||
                   (ovf && (stateCode != ST_OVF) && irqEnOvf));
  assign irqClr = regWe && (regAddr == A_STS) && regWdata[8];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {cfgWindow, cfgPeriod} <= '0;
      {irqEnRst, irqEnDiv, irqEnOvf, enDvfs, enRst, enDiv, cfgStop} <= '0;
      {thMid, thLow} <= '0;
      thHigh <= '0;
    end else if (regWe) begin
      if (regAddr == A_CFG) begin
        cfgWindow <= regWdata[31:24];
        cfgPeriod <= regWdata[23:8];
        {irqEnRst, irqEnDiv, irqEnOvf, enDvfs, enRst, enDiv, cfgStop} <= regWdata[6:0];
      end
      if (regAddr == A_THA) {thMid, thLow} <= regWdata;
      if (regAddr == A_THB) thHigh <= regWdata[15:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      countVal  <= '0;
      stateCode <= '0;
      validFlag <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (strobes.halted || strobes.windowEnd) acc <= '0;
      else if (strobes.accumulate)             acc <= satSum;

      if (strobes.halted) begin
        stateCode <= '0;
        validFlag <= 1'b0;
      end else if (strobes.windowEnd) begin
        countVal  <= satSum;
        validFlag <= !strobes.stopping;
        stateCode <= strobes.stopping ? '0 : (ovf ? ST_OVF : {1'b0, lvlNew});
      end

      if (irqSet)      irq <= 1'b1;
      else if (irqClr) irq <= 1'b0;
    end
  end

  assign dvfsReq   = validFlag && enDvfs && (effOld >= 2'd1);
  assign clkDivReq = validFlag && enDiv  && (effOld >= 2'd2);
  assign thermRst  = validFlag && enRst  && (effOld == 2'd3);

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CFG:   regRdata = {cfgWindow, cfgPeriod, 1'b0,
                           irqEnRst, irqEnDiv, irqEnOvf, enDvfs, enRst, enDiv, cfgStop};
      A_THA:   regRdata = {thMid, thLow};
      A_THB:   regRdata = {16'h0, thHigh};
      A_STS:   regRdata = {22'h0, validFlag, irq, 5'h0, stateCode};
      A_CNT:   regRdata = {countVal, 16'h0};
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/tmon_top.sv
module tmon_top
  import tmon_pkg::*;
#(
  parameter int PRESCALE = 32,
  parameter int TICK_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TICK_W-1:0] oscTicks,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq,
  output logic              dvfsReq,
  output logic              clkDivReq,
  output logic              thermRst
);
  tmonStrobes_t       strobes;
  logic               cfgStop;
  logic [PER_W-1:0]   cfgPeriod;
  logic [WIN_W-1:0]   cfgWindow;
  logic               validFlag;
  logic [STATE_W-1:0] stateCode;
  logic [CNT_W-1:0]   countVal;

  tmon_ctrl #(.PRESCALE(PRESCALE)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgStop(cfgStop), .cfgPeriod(cfgPeriod),
    .cfgWindow(cfgWindow), .strobes(strobes)
  );

  tmon_datapath #(.TICK_W(TICK_W), .ADDR_W(3)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .oscTicks(oscTicks),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .cfgStop(cfgStop), .cfgPeriod(cfgPeriod), .cfgWindow(cfgWindow),
    .irq(irq), .dvfsReq(dvfsReq), .clkDivReq(clkDivReq), .thermRst(thermRst),
    .validFlag(validFlag), .stateCode(stateCode), .countVal(countVal)
  );
endmodule

// File: rtl/tmon_checker.sv
module tmon_checker (
  input logic        clk,
  input logic        rstN,
  input logic        irq,
  input logic        dvfsReq,
  input logic        clkDivReq,
  input logic        thermRst,
  input logic        windowEnd,
  input logic        stopping,
  input logic        halted,
  input logic        validFlag,
  input logic [2:0]  stateCode,
  input logic [15:0] countVal
);
  a_r6_irq_only_at_window: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(windowEnd && !stopping));

  a_r8_valid_from_window: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validFlag) |-> $past(windowEnd));

  a_r9_halt_clears_valid: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> !validFlag);

  a_r5_actions_need_valid: assert property (@(posedge clk) disable iff (!rstN)
    !validFlag |-> (!dvfsReq && !clkDivReq && !thermRst));

  a_r4_state_legal: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode != 3'd4) && (stateCode < 3'd6));

  a_r2_count_held: assert property (@(posedge clk) disable iff (!rstN)
    !$past(windowEnd) |-> $stable(countVal));

  a_r3_ovf_saturated: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd5) |-> (countVal == 16'hFFFF));
endmodule

bind tmon_top tmon_checker u_chk (
  .clk(clk), .rstN(rstN), .irq(irq), .dvfsReq(dvfsReq), .clkDivReq(clkDivReq),
  .thermRst(thermRst), .windowEnd(strobes.windowEnd), .stopping(strobes.stopping),
  .halted(strobes.halted), .validFlag(validFlag), .stateCode(stateCode), .countVal(countVal)
);

// File: tb/tb_tmon_top.sv
module tb_tmon_top;
  localparam int PRE = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  oscTicks = '0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irq, dvfsReq, clkDivReq, thermRst;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tmon_top #(.PRESCALE(PRE), .TICK_W(4)) dut (
    .clk(clk), .rstN(rstN), .oscTicks(oscTicks), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .dvfsReq(dvfsReq),
    .clkDivReq(clkDivReq), .thermRst(thermRst)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Caller is at a negedge; the write lands on the next posedge.
  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  function automatic logic [15:0] expCount(input int n, input int t);
    int s = n * PRE * t;
    return (s > 65535) ? 16'hFFFF : 16'(s);
  endfunction

  function automatic int expLevel(input logic [15:0] c, input int a, input int b, input int h);
    return int'(c >= a) + int'(c >= b) + int'(c >= h);
  endfunction

  function automatic logic [31:0] mkCfg(input int n, input int m, input logic [5:0] en, input bit stop);
    return {8'(n), 16'(m), 1'b0, en, stop};
  endfunction

  initial begin
    #(20 * 190000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] prevCfg;
    logic [15:0] heldCount;
    int seedDummy;
    seedDummy = $urandom(32'd4711);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      regRead(3'(a), rd);
      check($sformatf("R1 reset reg %0d", a), rd, 32'h0);
    end
    check("R1 reset outputs", {28'h0, irq, dvfsReq, clkDivReq, thermRst}, 32'h0);
    oscTicks = 4'd7;
    repeat (300) @(negedge clk);
    regRead(3'd3, rd);
    check("R1 no measurement with M=N=0", rd, 32'h0);

    // R1: N greater than M stays idle
    regWrite(3'd0, mkCfg(4, 2, 6'h3F, 1'b0));
    repeat (500) @(negedge clk);
    regRead(3'd3, rd);
    check("R1 idle when N>M valid", rd[9], 1'b0);
    regRead(3'd4, rd);
    check("R1 idle when N>M count", rd, 32'h0);

    // R10: register readback
    regWrite(3'd0, 32'hAB12_34FF);
    regRead(3'd0, rd);
    check("R10 config readback bit7 clear", rd, 32'hAB12_347F);
    regWrite(3'd0, 32'h1);
    prevCfg = 32'h1;
    heldCount = 16'h0;

    // Random runs: R2, R4, R5, R6, R8, R9, R10
    for (int it = 0; it < 8; it++) begin
      int t = $urandom_range(0, 15);
      int n = $urandom_range(1, 4);
      int m = n + $urandom_range(0, 3);
      int th1 = $urandom_range(0, 2047);
      int th2 = $urandom_range(0, 2047);
      int th3 = $urandom_range(0, 2047);
      logic [5:0] en = 6'($urandom);
      logic [15:0] c;
      int lv;

      regWrite(3'd0, prevCfg | 32'h1);
      repeat (300) @(negedge clk);
      regRead(3'd3, rd);
      check("R9 stopped valid and state", {rd[9], rd[2:0]}, 4'h0);
      check("R9 stopped actions", {dvfsReq, clkDivReq, thermRst}, 3'b000);
      regRead(3'd4, rd);
      check("R9 count of last window", rd[31:16], heldCount);
      regWrite(3'd3, 32'h100);
      oscTicks = 4'(t ^ 5);
      repeat (200) @(negedge clk);
      regRead(3'd4, rd);
      check("R9 count held while stopped", rd[31:16], heldCount);
      check("R9 no interrupt while stopped", irq, 1'b0);

      oscTicks = 4'(t);
      regWrite(3'd1, {16'(th2), 16'(th1)});
      regWrite(3'd2, 32'(th3));
      regRead(3'd1, rd);
      check("R10 threshold pair readback", rd, {16'(th2), 16'(th1)});
      prevCfg = mkCfg(n, m, en, 1'b0);
      regWrite(3'd0, prevCfg);
      regRead(3'd3, rd);
      check("R8 valid clear right after start", rd[9], 1'b0);
      repeat (2 * (m + n) * PRE + 10) @(negedge clk);

      c = expCount(n, t);
      lv = expLevel(c, th1, th2, th3);
      heldCount = c;
      regRead(3'd4, rd);
      check($sformatf("R2 count n=%0d t=%0d", n, t), rd[31:16], c);
      regRead(3'd3, rd);
      check("R4 level", rd[2:0], 3'(lv));
      check("R8 valid after window", rd[9], 1'b1);
      check("R6 irq on rise from level 0", irq, (lv >= 1));
      check("R5 actions", {dvfsReq, clkDivReq, thermRst},
            {en[2] && lv >= 1, en[0] && lv >= 2, en[1] && lv >= 3});
    end

    // R10: writes to the result register and unmapped addresses are ignored
    regWrite(3'd4, 32'h1234_5678);
    regWrite(3'd6, 32'hFFFF_FFFF);
    regRead(3'd4, rd);
    check("R10 result write ignored", rd[31:16], heldCount);
    regRead(3'd0, rd);
    check("R10 unmapped write ignored", rd, prevCfg);

    // Collision and enable gating: one-unit windows back to back
    regWrite(3'd0, prevCfg | 32'h1);
    repeat (300) @(negedge clk);
    oscTicks = 4'd5;
    regWrite(3'd1, {16'd200, 16'd100});
    regWrite(3'd2, 32'd300);
    regWrite(3'd3, 32'h100);
    regWrite(3'd0, mkCfg(1, 1, 6'b000111, 1'b0));
    for (int w = 0; w < 200 && !irq; w++) @(negedge clk);
    check("R6 level-1 rise interrupts", irq, 1'b1);
    check("R5 level 1 only dvfs", {dvfsReq, clkDivReq, thermRst}, 3'b100);
    oscTicks = 4'd15;
    regWrite(3'd3, 32'h100);
    check("R7 clear on quiet cycle", irq, 1'b0);
    repeat (31) @(negedge clk);
    regRead(3'd3, rd);
    check("R4 level 3 reached", rd[2:0], 3'd3);
    check("R6 level 2/3 masked", irq, 1'b0);
    check("R5 level 3 all actions", {dvfsReq, clkDivReq, thermRst}, 3'b111);
    oscTicks = 4'd0;
    regWrite(3'd0, mkCfg(1, 1, 6'b111111, 1'b0));
    repeat (31) @(negedge clk);
    regRead(3'd3, rd);
    check("R4 level back to 0", rd[2:0], 3'd0);
    check("R6 no interrupt on fall", irq, 1'b0);
    oscTicks = 4'd15;
    repeat (31) @(negedge clk);
    regWrite(3'd3, 32'h100);
    check("R7 set wins over same-cycle clear", irq, 1'b1);
    regRead(3'd3, rd);
    check("R7 state after collision", rd[2:0], 3'd3);
    regWrite(3'd3, 32'h100);
    check("R7 clear one cycle later", irq, 1'b0);

    // R3: overflow
    regWrite(3'd0, 32'h1);
    repeat (100) @(negedge clk);
    regWrite(3'd1, {16'd1000, 16'd1000});
    regWrite(3'd2, 32'd1000);
    regWrite(3'd3, 32'h100);
    oscTicks = 4'd15;
    regWrite(3'd0, mkCfg(255, 255, 6'b111111, 1'b0));
    rd = '0;
    for (int w = 0; w < 20000 && !rd[9]; w++) begin
      @(negedge clk);
      regRead(3'd3, rd);
    end
    check("R3 overflow state", rd[2:0], 3'd5);
    regRead(3'd4, rd);
    check("R3 saturated count", rd[31:16], 16'hFFFF);
    check("R3 overflow acts as level 3", {dvfsReq, clkDivReq, thermRst}, 3'b111);
    check("R6 overflow interrupt", irq, 1'b1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule